// File: doc/BRIEF.md
# Mode-Selectable Synchronous Clock Divider Tree

This block derives a set of related board clocks from one master clock that runs at twice the CPU clock rate. A three-bit select picks a rate family (CPU clock near 100 MHz or near 133 MHz), a quiet three-state mode, or one of several codes that behave as quiet. In a running mode the block produces CPU clocks, a CPU-half clock, a 66 MHz clock, PCI clocks and an interrupt-controller clock. Every output comes from a register clocked by the master clock, and each output has a fixed rising-edge offset from the start of a shared frame.

The divide ratios depend on the rate family. In the 100 MHz family the 66 MHz clock is the master clock divided by three. It uses a register on the rising edge and a register on the falling edge, so that it still has an even duty cycle. All dividers share one frame counter, which is 12 master cycles long in the 100 MHz family and 16 master cycles long in the 133 MHz family. The select inputs and the active-low power-down input are sampled only at the last cycle of a frame. A new mode therefore never cuts a pulse short, and it always starts with a full-width pulse. The block also drives a common output-enable and an enable for a separate 48 MHz domain.

Top module: `clkdiv_tree`

## Requirements
- R1: The select code is {sel_fast, sel_mode[1], sel_mode[0]}. When sel_mode[1] is 0 (codes 000, 001, 100 and 101: three-state, test and reserved), clk_oe is 0 and every clock output is 0. When sel_mode[1] is 1, clk_oe is 1. After reset clk_oe is 0 and all outputs are 0.
- R2: usb_en is 1 only when the active code is 011 or 111 and power-down is not in effect.
- R3: In a running mode, cpu_clk is high in the even cycles of the frame. cpu_half_clk is high in cycles where (frame index mod 4) is 0 or 1.
- R4: With sel_fast=0, the frame is 12 cycles long. mid_clk divides the master clock by 3 and is high for 1.5 master cycles: all of phase 0 and the first half of phase 1. pci_clk divides by 6 and apic_clk divides by 12, both with 50% duty.
- R5: With sel_fast=1, the frame is 16 cycles long. mid_clk divides the master clock by 4, pci_clk by 8 and apic_clk by 16, all with 50% duty.
- R6: Within a frame, the first rising edges fall at these frame indices: cpu_clk at 0, mid_clk at 1, apic_clk at 1, pci_clk at 2. The phase of each output is (frame index minus its delay) modulo the frame length.
- R7: The inputs sel_fast, sel_mode and pwrdn_n are sampled only in the last cycle of a frame. Until then the outputs keep the pattern of the previous mode, and the new mode starts at frame index 0.
- R8: When pwrdn_n=0 is in effect, every clock output is held at 0 and clk_oe follows the mode decode.
- R9: All copies within one clock group are identical at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the CPU clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_fast | input | 1 | Rate family: 1 selects 133 MHz, 0 selects 100 MHz |
| sel_mode | input | 2 | Mode bits; bit 1 enables the clocks, bit 0 enables the 48 MHz domain |
| pwrdn_n | input | 1 | Active-low power-down request |
| cpu_clk | output | CPU_COPIES | CPU clock copies |
| cpu_half_clk | output | 1 | CPU clock divided by 2 |
| mid_clk | output | MID_COPIES | 66 MHz clock copies |
| pci_clk | output | PCI_COPIES | PCI clock copies |
| apic_clk | output | 1 | Interrupt-controller clock |
| clk_oe | output | 1 | Output enable for all clock drivers |
| usb_en | output | 1 | Enable for the separate 48 MHz domain |

## Verification
The assertions assume that sel_fast, sel_mode and pwrdn_n are synchronous to the master clock and never change close to a clock edge. They also assume that the master clock keeps running during power-down, so the frame counter can still reach a wrap point. The stimulus changes these inputs only in the middle of a clock phase. It changes them at deliberately chosen frame indices, some of them in mid-frame, to exercise the deferral to the wrap point. A cycle-accurate model of the frame index, built from the requirements alone, gives the expected level of every output for both halves of every master cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef struct packed {
    logic act;   // clocks running, drivers enabled
    logic fast;  // 133 MHz family
    logic e48;   // 48 MHz domain enabled
  } mode_t;

  function automatic mode_t decode_mode(input logic [2:0] code);
    mode_t m;
    m.act  = code[1];
    m.fast = code[2];
    m.e48  = code[1] & code[0];
    return m;
  endfunction

endpackage

// File: rtl/clkdiv_mode_decode.sv
module clkdiv_mode_decode
  import clkdiv_pkg::*;
(
  input  logic       sel_fast,
  input  logic [1:0] sel_mode,
  output mode_t      mode
);
  always_comb mode = decode_mode({sel_fast, sel_mode});
endmodule

// File: rtl/clkdiv_frame_ctl.sv
module clkdiv_frame_ctl
  import clkdiv_pkg::*;
#(
  parameter int FRAME_S = 12,
  parameter int FRAME_F = 16,
  parameter int FW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_t         req_mode,
  input  logic          req_pdn,
  output logic [FW-1:0] f_nxt,
  output logic          fast_nxt,
  output logic          run_nxt,
  output logic          wrap,
  output logic          act_q,
  output logic          fast_q,
  output logic          e48_q,
  output logic          pdn_q
);
  logic [FW-1:0] f_q;
  logic [FW-1:0] last;
  logic          act_n, e48_n, pdn_n;

  assign last = fast_q ? FW'(FRAME_F - 1) : FW'(FRAME_S - 1);
  assign wrap = (f_q == last);

  // State is only allowed to move at the frame wrap point.
  always_comb begin
    if (wrap) begin
      act_n    = req_mode.act;
      fast_nxt = req_mode.fast;
      e48_n    = req_mode.e48;
      pdn_n    = req_pdn;
      f_nxt    = '0;
    end else begin
      act_n    = act_q;
      fast_nxt = fast_q;
      e48_n    = e48_q;
      pdn_n    = pdn_q;
      f_nxt    = f_q + FW'(1);
    end
  end

  assign run_nxt = act_n & pdn_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= '0;
      act_q  <= 1'b0;
      fast_q <= 1'b0;
      e48_q  <= 1'b0;
      pdn_q  <= 1'b1;
    end else begin
      f_q    <= f_nxt;
      act_q  <= act_n;
      fast_q <= fast_nxt;
      e48_q  <= e48_n;
      pdn_q  <= pdn_n;
    end
  end
endmodule

// File: rtl/clkdiv_phase_div.sv
module clkdiv_phase_div #(
  parameter int DIV_S   = 3,
  parameter int DIV_F   = 4,
  parameter int DLY     = 0,
  parameter int FRAME_S = 12,
  parameter int FRAME_F = 16,
  parameter int FW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] f_nxt,
  input  logic          fast_nxt,
  input  logic          run_nxt,
  output logic          q
);
  localparam int ODD_S = DIV_S % 2;
  localparam int ODD_F = DIV_F % 2;

  logic [FW-1:0] pos_s, pos_f;
  logic          lvl_s, lvl_f, a_d, a_q;

  // Phase of this output within the frame, after its own delay.
  always_comb begin
    pos_s = FW'((32'(f_nxt) + FRAME_S - DLY) % FRAME_S);
    pos_f = FW'((32'(f_nxt) + FRAME_F - DLY) % FRAME_F);
    lvl_s = (ODD_S != 0) ? ((32'(pos_s) % DIV_S) == 0)
                         : ((32'(pos_s) % DIV_S) < (DIV_S / 2));
    lvl_f = (ODD_F != 0) ? ((32'(pos_f) % DIV_F) == 0)
                         : ((32'(pos_f) % DIV_F) < (DIV_F / 2));
    a_d   = run_nxt & (fast_nxt ? lvl_f : lvl_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= 1'b0;
    else        a_q <= a_d;
  end

  generate
    if (ODD_S != 0 || ODD_F != 0) begin : g_odd
      logic odd_q, b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) odd_q <= 1'b0;
        else        odd_q <= run_nxt & (fast_nxt ? (ODD_F != 0) : (ODD_S != 0));
      end
      // Falling-edge copy stretches the pulse by half a master cycle.
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else        b_q <= a_q & odd_q;
      end
      assign q = a_q | b_q;
    end else begin : g_even
      assign q = a_q;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
  import clkdiv_pkg::*;
#(
  parameter int CPU_COPIES   = 3,
  parameter int MID_COPIES   = 3,
  parameter int PCI_COPIES   = 10,
  parameter int CPU_DIV      = 2,
  parameter int HALF_DIV     = 4,
  parameter int MID_DIV_S    = 3,
  parameter int MID_DIV_F    = 4,
  parameter int PCI_DIV_S    = 6,
  parameter int PCI_DIV_F    = 8,
  parameter int APIC_DIV_S   = 12,
  parameter int APIC_DIV_F   = 16,
  parameter int MID_DLY      = 1,
  parameter int PCI_DLY      = 2,
  parameter int APIC_DLY     = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_fast,
  input  logic [1:0]            sel_mode,
  input  logic                  pwrdn_n,
  output logic [CPU_COPIES-1:0] cpu_clk,
  output logic                  cpu_half_clk,
  output logic [MID_COPIES-1:0] mid_clk,
  output logic [PCI_COPIES-1:0] pci_clk,
  output logic                  apic_clk,
  output logic                  clk_oe,
  output logic                  usb_en
);
  localparam int FRAME_S   = APIC_DIV_S;
  localparam int FRAME_F   = APIC_DIV_F;
  localparam int FRAME_MAX = (FRAME_S > FRAME_F) ? FRAME_S : FRAME_F;
  localparam int FW        = $clog2(FRAME_MAX);

  mode_t         req_mode;
  logic [FW-1:0] f_nxt;
  logic          fast_nxt, run_nxt, frame_wrap;
  logic          act_q, fast_q, e48_q, pdn_q;
  logic          cpu_q, half_q, mid_q, pci_q, apic_q;

  clkdiv_mode_decode u_dec (
    .sel_fast (sel_fast),
    .sel_mode (sel_mode),
    .mode     (req_mode)
  );

  clkdiv_frame_ctl #(.FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_mode (req_mode),
    .req_pdn  (pwrdn_n),
    .f_nxt    (f_nxt),
    .fast_nxt (fast_nxt),
    .run_nxt  (run_nxt),
    .wrap     (frame_wrap),
    .act_q    (act_q),
    .fast_q   (fast_q),
    .e48_q    (e48_q),
    .pdn_q    (pdn_q)
  );

  clkdiv_phase_div #(.DIV_S(CPU_DIV), .DIV_F(CPU_DIV), .DLY(0),
                     .FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_cpu (
    .clk(clk), .rst_n(rst_n), .f_nxt(f_nxt), .fast_nxt(fast_nxt),
    .run_nxt(run_nxt), .q(cpu_q));

  clkdiv_phase_div #(.DIV_S(HALF_DIV), .DIV_F(HALF_DIV), .DLY(0),
                     .FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_half (
    .clk(clk), .rst_n(rst_n), .f_nxt(f_nxt), .fast_nxt(fast_nxt),
    .run_nxt(run_nxt), .q(half_q));

  clkdiv_phase_div #(.DIV_S(MID_DIV_S), .DIV_F(MID_DIV_F), .DLY(MID_DLY),
                     .FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_mid (
    .clk(clk), .rst_n(rst_n), .f_nxt(f_nxt), .fast_nxt(fast_nxt),
    .run_nxt(run_nxt), .q(mid_q));

  clkdiv_phase_div #(.DIV_S(PCI_DIV_S), .DIV_F(PCI_DIV_F), .DLY(PCI_DLY),
                     .FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_pci (
    .clk(clk), .rst_n(rst_n), .f_nxt(f_nxt), .fast_nxt(fast_nxt),
    .run_nxt(run_nxt), .q(pci_q));

  clkdiv_phase_div #(.DIV_S(APIC_DIV_S), .DIV_F(APIC_DIV_F), .DLY(APIC_DLY),
                     .FRAME_S(FRAME_S), .FRAME_F(FRAME_F), .FW(FW)) u_apic (
    .clk(clk), .rst_n(rst_n), .f_nxt(f_nxt), .fast_nxt(fast_nxt),
    .run_nxt(run_nxt), .q(apic_q));

  // Fan-out to the replicated pins.
  generate
    for (genvar i = 0; i < CPU_COPIES; i++) begin : g_cpu
      assign cpu_clk[i] = cpu_q;
    end
    for (genvar i = 0; i < MID_COPIES; i++) begin : g_mid
      assign mid_clk[i] = mid_q;
    end
    for (genvar i = 0; i < PCI_COPIES; i++) begin : g_pci
      assign pci_clk[i] = pci_q;
    end
  endgenerate

  assign cpu_half_clk = half_q;
  assign apic_clk     = apic_q;
  assign clk_oe       = act_q;
  assign usb_en       = act_q & e48_q & pdn_q;
endmodule

// File: rtl/clkdiv_tree_chk.sv
module clkdiv_tree_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu0,
  input logic half,
  input logic mid0,
  input logic pci0,
  input logic apic,
  input logic clk_oe,
  input logic usb_en,
  input logic wrap,
  input logic act_q,
  input logic fast_q,
  input logic pdn_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> !(cpu0 | half | mid0 | pci0 | apic));

  assert_usb_needs_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    usb_en |-> clk_oe);

  assert_half_on_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half) |-> cpu0);

  assert_apic_lags_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(apic) |-> !cpu0);

  assert_hold_between_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_q) && $stable(fast_q) && $stable(pdn_q)));

  assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && !pdn_q) |-> !(cpu0 | half | mid0 | pci0 | apic));
endmodule

bind clkdiv_tree clkdiv_tree_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cpu0   (cpu_clk[0]),
  .half   (cpu_half_clk),
  .mid0   (mid_clk[0]),
  .pci0   (pci_clk[0]),
  .apic   (apic_clk),
  .clk_oe (clk_oe),
  .usb_en (usb_en),
  .wrap   (frame_wrap),
  .act_q  (act_q),
  .fast_q (fast_q),
  .pdn_q  (pdn_q)
);

// File: tb/clkdiv_tree_tb.sv
module clkdiv_tree_tb;
  localparam int NC = 3;
  localparam int NM = 3;
  localparam int NP = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_fast = 1'b0;
  logic [1:0]    sel_mode = 2'b00;
  logic          pwrdn_n = 1'b1;
  logic [NC-1:0] cpu_clk;
  logic          cpu_half_clk;
  logic [NM-1:0] mid_clk;
  logic [NP-1:0] pci_clk;
  logic          apic_clk, clk_oe, usb_en;

  clkdiv_tree u_dut (
    .clk(clk), .rst_n(rst_n), .sel_fast(sel_fast), .sel_mode(sel_mode),
    .pwrdn_n(pwrdn_n), .cpu_clk(cpu_clk), .cpu_half_clk(cpu_half_clk),
    .mid_clk(mid_clk), .pci_clk(pci_clk), .apic_clk(apic_clk),
    .clk_oe(clk_oe), .usb_en(usb_en));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Bench model of the frame and the latched mode.
  int mf = 0;
  bit m_act = 0, m_fast = 0, m_e48 = 0, m_pdn = 1, pend = 0;
  bit fr_ok = 0;
  int fc, fm, fp, fa;

  function automatic int flen(bit fast);
    return fast ? 16 : 12;
  endfunction

  function automatic bit lvl(int div, int dly, int f, int h, bit fast);
    int l  = flen(fast);
    int p  = (f + l - dly) % l;
    int pp = (p + l - 1) % l;
    if (div % 2 == 1) return (p % div == 0) || (h == 0 && pp % div == 0);
    return (p % div) < (div / 2);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sample(int h);
    bit run = m_act & m_pdn;
    string tg, tr;
    bit ec, eh, em, ep, ea;
    tr = m_fast ? "R5" : "R4";
    tg = !m_act ? "R1" : (!m_pdn ? "R8" : (pend ? "R7" : ""));
    ec = run & lvl(2, 0, mf, h, m_fast);
    eh = run & lvl(4, 0, mf, h, m_fast);
    em = run & lvl(m_fast ? 4 : 3, 1, mf, h, m_fast);
    ep = run & lvl(m_fast ? 8 : 6, 2, mf, h, m_fast);
    ea = run & lvl(m_fast ? 16 : 12, 1, mf, h, m_fast);
    chk(cpu_clk[0] == ec, tg != "" ? tg : "R3", "cpu_clk", cpu_clk[0], ec);
    chk(cpu_half_clk == eh, tg != "" ? tg : "R3", "cpu_half_clk", cpu_half_clk, eh);
    chk(mid_clk[0] == em, tg != "" ? tg : tr, "mid_clk", mid_clk[0], em);
    chk(pci_clk[0] == ep, tg != "" ? tg : tr, "pci_clk", pci_clk[0], ep);
    chk(apic_clk == ea, tg != "" ? tg : tr, "apic_clk", apic_clk, ea);
    // R9: copies agree
    chk((cpu_clk == {NC{cpu_clk[0]}}) && (mid_clk == {NM{mid_clk[0]}}) &&
        (pci_clk == {NP{pci_clk[0]}}), "R9", "copies", 0, 0);
    if (h == 0) begin
      chk(clk_oe == m_act, "R1", "clk_oe", clk_oe, m_act);
      chk(usb_en == (m_act & m_e48 & m_pdn), "R2", "usb_en", usb_en,
          m_act & m_e48 & m_pdn);
      if (mf == 0) begin
        fr_ok = run; fc = -1; fm = -1; fp = -1; fa = -1;
      end
      if (cpu_clk[0] && fc < 0) fc = mf;
      if (mid_clk[0] && fm < 0) fm = mf;
      if (pci_clk[0] && fp < 0) fp = mf;
      if (apic_clk && fa < 0) fa = mf;
    end else if (mf == flen(m_fast) - 1 && fr_ok) begin
      // R6: first rising edges of a full running frame
      chk(fc == 0, "R6", "cpu first high", fc, 0);
      chk(fm == 1, "R6", "mid first high", fm, 1);
      chk(fp == 2, "R6", "pci first high", fp, 2);
      chk(fa == 1, "R6", "apic first high", fa, 1);
      fr_ok = 0;
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (mf == flen(m_fast) - 1) begin
        m_act = sel_mode[1]; m_fast = sel_fast;
        m_e48 = sel_mode[1] & sel_mode[0]; m_pdn = pwrdn_n;
        mf = 0;
      end else begin
        mf++;
      end
      pend = (m_act != sel_mode[1]) || (m_fast != sel_fast) ||
             (m_e48 != (sel_mode[1] & sel_mode[0])) || (m_pdn != pwrdn_n);
      #5 sample(0);
      #10 sample(1);
    end
  endtask

  task automatic go_to(int f);
    while (mf != f) step(1);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    chk(clk_oe == 0 && usb_en == 0 && cpu_clk == 0 && mid_clk == 0 &&
        pci_clk == 0 && apic_clk == 0 && cpu_half_clk == 0,
        "R1", "reset outputs", 1, 0);
    rst_n = 1'b1;
    step(20);
    sel_mode = 2'b11; sel_fast = 1'b0;       // 011: 100 MHz, 48 on
    step(48);
    go_to(5); sel_fast = 1'b1;               // mid-frame switch to 111 (R7)
    step(56);
    go_to(3); sel_mode = 2'b10;              // 110: 48 off (R2)
    step(40);
    go_to(7); pwrdn_n = 1'b0;                // R8 power-down
    step(40);
    pwrdn_n = 1'b1;
    step(40);
    for (int c = 0; c < 8; c++) begin        // every select code (R1, R4, R5)
      go_to(4);
      {sel_fast, sel_mode} = 3'(c);
      step(40);
    end
    go_to(9); sel_fast = 1'b0; sel_mode = 2'b10;  // 010 (R4)
    step(40);
    go_to(6); sel_mode = 2'b00;              // run to quiet mid-frame (R7)
    step(30);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule